// File: doc/BRIEF.md
# Bounded Address Generator

This unit forms a 16-bit address by adding a displacement to one of six index registers, then returns the address only when the high byte of the sum lies within a programmable unsigned window. A single bidirectional 16-bit bus is shared by every transfer. The host uses it to load the index registers and the window limits, to present the displacement, and to read back the index in use and the final address.

An operation runs for five clock cycles. In cycle 1 the host raises `start`, places the displacement on the bus and selects an index with `sel`. In cycles 2 and 3 the unit drives the selected index onto the bus. In cycle 4 nobody drives the bus. In cycle 5 the unit either drives the address or raises `fault` and leaves the bus released.

The window check does not wait for the adder. While the adder runs, the displacement's high byte is subtracted from the lower limit and both possible outcomes of the low-byte carry are compared with the index's high byte. Cycle 5 selects between these two outcomes using the real carry. `near` reports the cases where the carry decided the verdict.

Top module: `bounded_agu`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `fault`, `near` and `drive` are low and the bus is released. All six index registers hold 0, the upper limit is 0xFF and the lower limit is 0x00.
- R2: When the unit is idle, `wr` is high and `start` is low, a `sel` value from 0 to 5 stores the bus value into that index register at the clock edge.
- R3: A store with `sel` = 6 loads the upper limit from bus bits 15:8 and the lower limit from bus bits 7:0. A store with `sel` = 7 changes no register.
- R4: A store is ignored when `busy` is high or when `start` is high in the same cycle.
- R5: `start` while idle captures the displacement from the bus. That cycle is cycle 1. `busy` is then high in cycles 2 to 5, and `done` is high in cycle 5 only. `start` while busy is ignored.
- R6: In cycles 2 and 3 the unit drives the selected index register onto the bus, with `drive` high.
- R7: In cycle 5, the unit drives (index + displacement) mod 2^16 onto the bus with `fault` low if and only if lower ≤ high byte of that sum ≤ upper, compared unsigned and inclusive.
- R8: If the check in R7 fails, `fault` is high in cycle 5 and the bus is left undriven (`drive` low).
- R9: `sel` = 6 or 7 at start is an invalid index. The index value reads as 0 and the operation ends with `fault`.
- R10: If lower > upper, every operation ends with `fault`.
- R11: In cycle 5, for a valid index, `near` is high if and only if the verdict for index_hi + disp_hi with carry 0 differs from the verdict with carry 1.
- R12: The unit does not drive the bus while idle or in cycle 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an operation; the displacement is on the bus |
| sel | input | 3 | Index number at start; store target with `wr` (0-5 index, 6 limits) |
| wr | input | 1 | Store command |
| abus | inout | 16 | Shared data bus |
| busy | output | 1 | Operation in cycles 2 to 5 |
| done | output | 1 | Cycle 5 of an operation |
| fault | output | 1 | Window check failed (cycle 5) |
| near | output | 1 | Low-byte carry decided the verdict (cycle 5) |
| drive | output | 1 | Unit is driving `abus` |

## Verification
The properties assume that the host obeys the bus protocol. The host drives `abus` only in cycle 1 of an operation, in store cycles and in cycle 4, so the unit's own drive never meets another driver. The host also holds its own drive until the clock edge that samples it, and the stimulus releases the bus with non-blocking updates at that edge. The sweep covers every index number, including the two invalid ones, and several window shapes: normal, full, inverted and single-value. It also pairs displacement high bytes with low bytes that force and suppress the low carry, so the carry-selected verdict and the `near` flag are exercised on both sides.

// File: rtl/bagu_pkg.sv
// Shared definitions for the bounded address generator.
// Assumes: operations are five cycles; the phase code only names cycles 2..5.
package bagu_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,  // no operation; cycle 1 is spent here with start high
        PH_FETCH  = 3'd1,  // cycle 2: index value on the bus
        PH_ADD_LO = 3'd2,  // cycle 3: index on bus, low half added, window compared
        PH_ADD_HI = 3'd3,  // cycle 4: high half added, bus released
        PH_OUT    = 3'd4   // cycle 5: verdict, address or fault
    } phase_t;
endpackage

// File: rtl/bagu_regfile.sv
// Index register file plus window limit register.
// Assumes: the write enable is already qualified by the caller (idle, no start);
// NIDX < 2**SELW, and target NIDX selects the limits; HW <= AW/2.
module bagu_regfile #(
    parameter int AW   = 16,
    parameter int HW   = 8,
    parameter int NIDX = 6,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic [SELW-1:0] rd_sel,
    output logic [AW-1:0]   rd_data,
    output logic [HW-1:0]   upper,
    output logic [HW-1:0]   lower
);
    localparam logic [SELW-1:0] LIM_SEL = SELW'(NIDX);

    logic [AW-1:0] idx_q [NIDX];

    for (genvar k = 0; k < NIDX; k++) begin : g_idx
        // Store one index register when its number is targeted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                idx_q[k] <= '0;
            else if (wr_en && wr_sel == SELW'(k))
                idx_q[k] <= wr_data;
        end
    end

    // Store the window limits: upper from the top byte, lower from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper <= '1;
            lower <= '0;
        end else if (wr_en && wr_sel == LIM_SEL) begin
            upper <= wr_data[AW-1 -: HW];
            lower <= wr_data[HW-1:0];
        end
    end

    // Read the selected index; an out-of-range number reads as zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NIDX; k++)
            if (rd_sel == SELW'(k))
                rd_data = idx_q[k];
    end
endmodule

// File: rtl/bagu_adder.sv
// Two-step split adder: low part in one cycle, high part plus carry in the next.
// Assumes: idx stays stable through both enables; cap comes before lo_en.
module bagu_adder #(
    parameter int AW = 16,
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          lo_en,
    input  logic          hi_en,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] sum,
    output logic          carry
);
    localparam int LW = AW - HW;

    logic [AW-1:0] disp_q;
    logic [LW-1:0] sum_lo;
    logic [HW-1:0] sum_hi;
    logic [LW:0]   lo_full;

    // Low half with its carry out.
    always_comb lo_full = {1'b0, disp_q[LW-1:0]} + {1'b0, idx[LW-1:0]};

    // Hold the displacement, then form the two halves in order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q <= '0;
            sum_lo <= '0;
            sum_hi <= '0;
            carry  <= 1'b0;
        end else begin
            if (cap)
                disp_q <= disp;
            if (lo_en) begin
                sum_lo <= lo_full[LW-1:0];
                carry  <= lo_full[LW];
            end
            if (hi_en)
                sum_hi <= disp_q[AW-1:LW] + idx[AW-1:LW] + HW'(carry);
        end
    end

    assign sum = {sum_hi, sum_lo};
endmodule

// File: rtl/bagu_bound.sv
// Early window check. At capture it forms lower - disp_hi and the window width.
// Later it compares index_hi against both carry outcomes, so the final verdict
// is a select on the low carry.
// Assumes: limits and disp_hi are valid at cap; idx_hi is valid at cmp_en.
module bagu_bound #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          cmp_en,
    input  logic [HW-1:0] disp_hi,
    input  logic [HW-1:0] upper,
    input  logic [HW-1:0] lower,
    input  logic [HW-1:0] idx_hi,
    output logic          pass0,
    output logic          pass1
);
    logic [HW-1:0] boff_q;
    logic [HW-1:0] wid_q;
    logic          ordered_q;
    logic [HW-1:0] t0;
    logic [HW-1:0] t1;

    // Offsets of the candidate high bytes from the lower limit (modular).
    always_comb begin
        t0 = HW'(idx_hi - boff_q);
        t1 = HW'(t0 + 1'b1);
    end

    // Precompute at capture, compare both carry cases later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boff_q    <= '0;
            wid_q     <= '0;
            ordered_q <= 1'b0;
            pass0     <= 1'b0;
            pass1     <= 1'b0;
        end else begin
            if (cap) begin
                boff_q    <= HW'(lower - disp_hi);
                wid_q     <= HW'(upper - lower);
                ordered_q <= (lower <= upper);
            end
            if (cmp_en) begin
                pass0 <= ordered_q && (t0 <= wid_q);
                pass1 <= ordered_q && (t1 <= wid_q);
            end
        end
    end
endmodule

// File: rtl/bounded_agu.sv
// Bounded address generator top: sequencer, bus drive and verdict.
// Assumes: the host releases abus outside cycle 1, store cycles and cycle 4.
module bounded_agu #(
    parameter int AW   = 16,
    parameter int HW   = 8,
    parameter int NIDX = 6,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SELW-1:0] sel,
    input  logic            wr,
    inout  wire  [AW-1:0]   abus,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic            near,
    output logic            drive
);
    import bagu_pkg::*;

    phase_t          phase;
    logic            start_ok;
    logic            wr_ok;
    logic [SELW-1:0] idx_q;
    logic            idx_ok_q;
    logic [AW-1:0]   idx_val;
    logic [HW-1:0]   upper;
    logic [HW-1:0]   lower;
    logic [AW-1:0]   sum;
    logic            carry;
    logic            pass0;
    logic            pass1;
    logic            verdict;
    logic [AW-1:0]   out_val;

    assign start_ok = start && (phase == PH_IDLE);
    assign wr_ok    = wr && (phase == PH_IDLE) && !start;

    // Step through the five-cycle operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else
            unique case (phase)
                PH_IDLE:   if (start_ok) phase <= PH_FETCH;
                PH_FETCH:  phase <= PH_ADD_LO;
                PH_ADD_LO: phase <= PH_ADD_HI;
                PH_ADD_HI: phase <= PH_OUT;
                default:   phase <= PH_IDLE;
            endcase
    end

    // Latch the index number and its validity at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            idx_ok_q <= 1'b0;
        end else if (start_ok) begin
            idx_q    <= sel;
            idx_ok_q <= (sel < SELW'(NIDX));
        end
    end

    bagu_regfile #(.AW(AW), .HW(HW), .NIDX(NIDX), .SELW(SELW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_sel  (sel),
        .wr_data (abus),
        .rd_sel  (idx_q),
        .rd_data (idx_val),
        .upper   (upper),
        .lower   (lower)
    );

    bagu_adder #(.AW(AW), .HW(HW)) u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (start_ok),
        .lo_en (phase == PH_ADD_LO),
        .hi_en (phase == PH_ADD_HI),
        .disp  (abus),
        .idx   (idx_val),
        .sum   (sum),
        .carry (carry)
    );

    bagu_bound #(.HW(HW)) u_bnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (start_ok),
        .cmp_en  (phase == PH_ADD_LO),
        .disp_hi (abus[AW-1 -: HW]),
        .upper   (upper),
        .lower   (lower),
        .idx_hi  (idx_val[AW-1 -: HW]),
        .pass0   (pass0),
        .pass1   (pass1)
    );

    // Finish the check with the real low carry and drive the outputs.
    always_comb begin
        verdict = idx_ok_q && (carry ? pass1 : pass0);
        busy    = (phase != PH_IDLE);
        done    = (phase == PH_OUT);
        fault   = done && !verdict;
        near    = done && idx_ok_q && (pass0 ^ pass1);
        drive   = (phase == PH_FETCH) || (phase == PH_ADD_LO) || (done && verdict);
        out_val = done ? sum : idx_val;
    end

    assign abus = drive ? out_val : 'z;
endmodule

// File: rtl/bagu_chk.sv
// Protocol checker for the bounded address generator, attached by bind.
// Assumes: the host keeps the bus protocol stated for the top module.
module bagu_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic fault,
    input logic near,
    input logic drive
);
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_five_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##4 done);
    assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_fault_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !drive);
    assert_fault_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);
    assert_pass_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> drive);
    assert_near_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        near |-> done);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive);
endmodule

bind bounded_agu bagu_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .fault (fault),
    .near  (near),
    .drive (drive)
);

// File: tb/bounded_agu_tb.sv
`timescale 1ns/1ps
module bounded_agu_tb;
    localparam int NIDX = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  sel = '0;
    logic        tb_oe = 1'b0;
    logic [15:0] tb_val = '0;
    wire  [15:0] abus;
    logic        busy, done, fault, near, drive;

    int          total = 0;
    int          bad = 0;
    logic [15:0] mdl_idx [NIDX];
    logic [7:0]  mdl_up = 8'hFF;
    logic [7:0]  mdl_lo = 8'h00;

    assign abus = tb_oe ? tb_val : 'z;

    always #2.5 clk = ~clk;

    bounded_agu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .wr(wr),
        .abus(abus), .busy(busy), .done(done), .fault(fault),
        .near(near), .drive(drive)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit inwin(input logic [7:0] h);
        return (mdl_lo <= mdl_up) && (h >= mdl_lo) && (h <= mdl_up);
    endfunction

    // Store cycle; the model follows R2/R3 (sel 7 changes nothing).
    task automatic store(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        wr = 1'b1; sel = s; tb_oe = 1'b1; tb_val = v;
        @(posedge clk);
        wr <= 1'b0; tb_oe <= 1'b0;
        if (s < 3'(NIDX)) mdl_idx[s] = v;
        else if (s == 3'd6) begin mdl_up = v[15:8]; mdl_lo = v[7:0]; end
    endtask

    // One operation; inject adds a start and a store while busy (R4, R5).
    task automatic run_op(input logic [2:0] s, input logic [15:0] d, input bit inject);
        logic [15:0] iv, sum;
        logic [7:0]  h0;
        bit          ok, ok0, ok1, nx;
        string       ftag;
        iv  = (s < 3'(NIDX)) ? mdl_idx[s] : 16'h0;
        sum = iv + d;
        h0  = iv[15:8] + d[15:8];
        ok0 = inwin(h0);
        ok1 = inwin(h0 + 8'd1);
        ok  = (s < 3'(NIDX)) && inwin(sum[15:8]);
        nx  = (s < 3'(NIDX)) && (ok0 != ok1);
        ftag = (s >= 3'(NIDX)) ? "R9 fault" : ((mdl_lo > mdl_up) ? "R10 fault" : "R8 fault");
        @(negedge clk);
        start = 1'b1; sel = s; tb_oe = 1'b1; tb_val = d;
        @(posedge clk);
        start <= 1'b0; tb_oe <= 1'b0;
        @(negedge clk);                              // cycle 2
        chk("R5 busy c2", busy, 1);
        chk("R6 drive c2", drive, 1);
        chk("R6 index c2", abus, iv);
        @(negedge clk);                              // cycle 3
        chk("R6 index c3", abus, iv);
        if (inject) start = 1'b1;
        @(negedge clk);                              // cycle 4
        start = 1'b0;
        chk("R12 quiet c4", drive, 0);
        if (inject) begin
            wr = 1'b1; sel = 3'd0; tb_oe = 1'b1; tb_val = 16'hDEAD;
            @(posedge clk);
            wr <= 1'b0; tb_oe <= 1'b0;
        end
        @(negedge clk);                              // cycle 5
        chk("R5 done c5", done, 1);
        chk(ftag, fault, !ok);
        chk("R7 drive", drive, ok);
        if (ok) chk("R7 address", abus, sum);
        chk("R11 near", near, nx);
        @(negedge clk);                              // cycle 6
        chk("R5 idle after", {busy, done}, 0);
        chk("R12 quiet idle", drive, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lims [5];
        logic [7:0]  lows [4];
        lims[0] = 16'h6020; lims[1] = 16'hFF00; lims[2] = 16'h7F80;
        lims[3] = 16'h5555; lims[4] = 16'hC0A1;
        lows[0] = 8'h00; lows[1] = 8'h09; lows[2] = 8'h80; lows[3] = 8'hFF;
        for (int k = 0; k < NIDX; k++) mdl_idx[k] = 16'h0;
        repeat (3) @(negedge clk);
        chk("R1 reset outs", {busy, done, fault, near, drive}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle outs", {busy, done, fault, near, drive}, 0);
        run_op(3'd3, 16'h0000, 1'b0);                // R1: zero index, full window
        run_op(3'd5, 16'hFFFF, 1'b0);
        for (int k = 0; k < NIDX; k++)
            store(3'(k), 16'(k * 16'h2B31 + 16'h00F7));  // R2
        store(3'd7, 16'h1234);                       // R3: no effect
        run_op(3'd2, 16'h0100, 1'b0);
        for (int b = 0; b < 5; b++) begin
            store(3'd6, lims[b]);                    // R3
            for (int s = 0; s < 8; s++)
                for (int j = 0; j < 16; j++)
                    for (int q = 0; q < 4; q++)
                        run_op(3'(s), {8'(j * 17), lows[q]}, (j == 0) && (q == 1));
        end
        // R4: store with start in the same cycle is dropped.
        @(negedge clk);
        start = 1'b1; wr = 1'b1; sel = 3'd1; tb_oe = 1'b1; tb_val = 16'h0040;
        @(posedge clk);
        start <= 1'b0; wr <= 1'b0; tb_oe <= 1'b0;
        repeat (6) @(negedge clk);
        run_op(3'd1, 16'h0000, 1'b0);
        finish_run();
    end
endmodule